// File: doc/BRIEF.md
# Multicycle Shared-Bus Control Sequencer

This block is the control unit of a small 16-bit word-addressed processor whose datapath moves every value over one shared bus. A state machine walks each instruction through three fetch steps: the program counter goes to the address register, memory is read into the data register, and the data register goes to the instruction register. A decode step follows, and then an execute path picked by the opcode. In each state the block drives at most one bus gate. It also drives the load strobes, the mux selects and the memory strobes.

The block holds the program counter, the memory address register and the memory data register, together with the bus multiplexer that joins them. The instruction register, the register file, the condition flags, the ALU and the address adder sit outside. Their results come back on `alu_res`, `addr_res`, `reg_rd` and `br_taken`. The memory port is a plain address/data/enable/write interface that waits on a ready input.

Top module: `bus_seq_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `pc_q` equals START_ADDR, the sequencer is in its first fetch step with only the PC gate active, and `illegal` is low.
- R2: Fetch is four states. (1) The PC is gated and `ld_mar` is set. (2) `mem_en` is read until ready, and then `ld_mdr` is set. (3) The MDR is gated, with `ld_ir`, `ld_pc` and `pc_sel`=0 (PC+1). (4) Decode, in which no gate, load or memory strobe is active.
- R3: `gate_oh` never has more than one bit set. Bit 0 is PC, bit 1 is MDR, bit 2 is ALU, bit 3 is address result and bit 4 is register read.
- R4: Operate opcodes are 0001 (add), 0101 (and) and 1001 (not). They drive `sr1_idx`=IR[8:6] and `sr2_idx`=IR[2:0]. `op2_imm` is set to IR[5]. `alu_fn` is 0 for add, 1 for and and 2 for not. One state gates the ALU with `ld_reg`, `ld_cc` and `dr_idx`=IR[11:9].
- R5: LD (0010, `addr_mode`=0, PC-relative 9-bit) and LDR (0110, `addr_mode`=2, base IR[8:6] plus 6-bit offset) load the address into MAR and read memory. They then gate the MDR into IR[11:9] and set the flags. LEA (1110) gates the PC-relative address straight into the register and sets the flags.
- R6: LDI (1010) and STI (1011) read a pointer word first, then gate the MDR into MAR. The second access uses that word as its address.
- R7: ST (0011), STR (0111) and STI load MAR with the address. They then gate register IR[11:9] into the MDR and do one write access. They leave the flags unchanged, and `mem_we` is never set without `mem_en`.
- R8: BR (0000) loads the PC with the PC-relative target (`pc_sel`=1) only when `br_taken` is high. Otherwise the PC keeps PC+1.
- R9: JMP (1100) loads the PC from base register IR[8:6] (`addr_mode`=3, `pc_sel`=2). JSR (0100) first writes the PC into register LINK_REG without touching the flags. It then jumps PC-relative with an 11-bit offset (`addr_mode`=1) when IR[11]=1, and to the base register otherwise.
- R10: TRAP (1111) writes the link register and then loads MAR with the zero-extended 8-bit vector (`addr_mode`=4). It reads memory and loads the PC from the MDR over the bus (`pc_sel`=3).
- R11: Every memory state holds while `mem_ready` is low. During the hold, `mem_en`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged.
- R12: Opcodes 1000 and 1101 enter a halt state. That state raises `illegal` and drives no gate, load or memory strobe until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_word | input | 16 | Current instruction register contents |
| br_taken | input | 1 | Branch condition met, from external flag logic |
| mem_ready | input | 1 | Memory access completes this cycle |
| mem_rdata | input | DW | Memory read data |
| alu_res | input | DW | External ALU result |
| addr_res | input | DW | External address adder result for `addr_mode` |
| reg_rd | input | DW | Register file read of `sr1_idx` |
| bus_q | output | DW | Shared bus value |
| gate_oh | output | 5 | One-hot bus gate (PC, MDR, ALU, ADDR, REG) |
| ld_mar | output | 1 | Address register load |
| ld_mdr | output | 1 | Data register load |
| ld_ir | output | 1 | Instruction register load from bus |
| ld_pc | output | 1 | Program counter load |
| ld_reg | output | 1 | Register file write of bus at `dr_idx` |
| ld_cc | output | 1 | Condition flags load from bus |
| pc_sel | output | 2 | PC source: 0 inc, 1 relative, 2 base, 3 bus |
| addr_mode | output | 3 | Address adder mode: 0 PC+off9, 1 PC+off11, 2 base+off6, 3 base, 4 vector |
| op2_imm | output | 1 | ALU second operand is the sign-extended immediate |
| alu_fn | output | 2 | ALU function: 0 add, 1 and, 2 not |
| sr1_idx | output | 3 | First register read index |
| sr2_idx | output | 3 | Second register read index |
| dr_idx | output | 3 | Register write index |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | DW | Memory address (MAR) |
| mem_wdata | output | DW | Memory write data (MDR) |
| pc_q | output | DW | Program counter |
| illegal | output | 1 | Sticky illegal-opcode halt |

## Verification
The bench runs a program that reaches every supported opcode at zero and at three wait cycles per access, and predicts the total cycle count from the per-path state counts. A sequencer that drops or adds a state, or fails to hold on `mem_ready`, shows up at once in that count. A taken branch that skips a write and a not-taken branch guard the `br_taken` use, so a design that ignored the flag would corrupt a register. Indirect store and load paths check that the pointer word, and not the pointer address, reaches the bus. The last word is an illegal opcode, and after it the outputs must stay quiet.

// File: rtl/bus_seq_pkg.sv
`timescale 1ns/1ps
package bus_seq_pkg;
   localparam int GN     = 5;
   localparam int GI_PC  = 0;
   localparam int GI_MDR = 1;
   localparam int GI_ALU = 2;
   localparam int GI_ADR = 3;
   localparam int GI_REG = 4;

   localparam logic [1:0] PCS_INC  = 2'd0;
   localparam logic [1:0] PCS_REL  = 2'd1;
   localparam logic [1:0] PCS_BASE = 2'd2;
   localparam logic [1:0] PCS_BUS  = 2'd3;

   localparam logic [2:0] AM_PC9   = 3'd0;
   localparam logic [2:0] AM_PC11  = 3'd1;
   localparam logic [2:0] AM_BASE6 = 3'd2;
   localparam logic [2:0] AM_BASE0 = 3'd3;
   localparam logic [2:0] AM_VEC   = 3'd4;

   localparam logic [1:0] FN_ADD = 2'd0;
   localparam logic [1:0] FN_AND = 2'd1;
   localparam logic [1:0] FN_NOT = 2'd2;

   localparam logic [3:0] OP_BR   = 4'h0;
   localparam logic [3:0] OP_ADD  = 4'h1;
   localparam logic [3:0] OP_LD   = 4'h2;
   localparam logic [3:0] OP_ST   = 4'h3;
   localparam logic [3:0] OP_JSR  = 4'h4;
   localparam logic [3:0] OP_AND  = 4'h5;
   localparam logic [3:0] OP_LDR  = 4'h6;
   localparam logic [3:0] OP_STR  = 4'h7;
   localparam logic [3:0] OP_NOT  = 4'h9;
   localparam logic [3:0] OP_LDI  = 4'hA;
   localparam logic [3:0] OP_STI  = 4'hB;
   localparam logic [3:0] OP_JMP  = 4'hC;
   localparam logic [3:0] OP_LEA  = 4'hE;
   localparam logic [3:0] OP_TRAP = 4'hF;

   typedef enum logic [4:0] {
      S_FMAR, S_FRD, S_FIR, S_DEC,
      S_OPR, S_LEA, S_EA, S_RDP, S_PTR, S_RD, S_WB,
      S_SD, S_WR, S_BR, S_JMP, S_LINK, S_JSR, S_TEA, S_TPC, S_ILL
   } seq_state_t;

   typedef struct packed {
      logic [GN-1:0] gate;
      logic          ld_mar;
      logic          ld_mdr;
      logic          ld_ir;
      logic          ld_pc;
      logic          ld_reg;
      logic          ld_cc;
      logic [1:0]    pc_sel;
      logic [2:0]    amode;
      logic          op2_imm;
      logic [1:0]    alu_fn;
      logic [2:0]    sr1;
      logic [2:0]    dr;
      logic          mem_en;
      logic          mem_we;
   } seq_ctrl_t;
endpackage

// File: rtl/bus_seq_fsm.sv
`timescale 1ns/1ps
module bus_seq_fsm
   import bus_seq_pkg::*;
#(
   parameter int LINK_REG = 7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [15:0] ir,
   input  logic        br_taken,
   input  logic        mem_ready,
   output seq_ctrl_t   ctl,
   output logic        halted
);
   localparam logic [2:0] LINK_IDX = 3'(LINK_REG);

   seq_state_t st, nxt;
   logic [3:0] opc;
   logic       unused_ir;

   assign opc       = ir[15:12];
   assign unused_ir = ^ir[4:3];
   assign halted    = (st == S_ILL);

   always_ff @(posedge clk) begin
      if (!rst_n) st <= S_FMAR;
      else        st <= nxt;
   end

   always_comb begin
      ctl     = '0;
      ctl.sr1 = ir[8:6];
      ctl.dr  = ir[11:9];
      nxt     = st;
      unique case (st)
         S_FMAR: begin
            ctl.gate[GI_PC] = 1'b1; ctl.ld_mar = 1'b1; nxt = S_FRD;
         end
         S_FRD: begin
            ctl.mem_en = 1'b1;
            if (mem_ready) begin ctl.ld_mdr = 1'b1; nxt = S_FIR; end
         end
         S_FIR: begin
            ctl.gate[GI_MDR] = 1'b1; ctl.ld_ir = 1'b1;
            ctl.pc_sel = PCS_INC; ctl.ld_pc = 1'b1; nxt = S_DEC;
         end
         S_DEC: begin
            unique case (opc)
               OP_ADD, OP_AND, OP_NOT:                  nxt = S_OPR;
               OP_LEA:                                  nxt = S_LEA;
               OP_LD, OP_LDR, OP_LDI, OP_ST, OP_STR, OP_STI: nxt = S_EA;
               OP_BR:                                   nxt = S_BR;
               OP_JMP:                                  nxt = S_JMP;
               OP_JSR, OP_TRAP:                         nxt = S_LINK;
               default:                                 nxt = S_ILL;
            endcase
         end
         S_OPR: begin
            ctl.op2_imm = ir[5];
            ctl.alu_fn  = (opc == OP_AND) ? FN_AND : (opc == OP_NOT) ? FN_NOT : FN_ADD;
            ctl.gate[GI_ALU] = 1'b1; ctl.ld_reg = 1'b1; ctl.ld_cc = 1'b1; nxt = S_FMAR;
         end
         S_LEA: begin
            ctl.amode = AM_PC9; ctl.gate[GI_ADR] = 1'b1;
            ctl.ld_reg = 1'b1; ctl.ld_cc = 1'b1; nxt = S_FMAR;
         end
         S_EA: begin
            ctl.amode = (opc == OP_LDR || opc == OP_STR) ? AM_BASE6 : AM_PC9;
            ctl.gate[GI_ADR] = 1'b1; ctl.ld_mar = 1'b1;
            if (opc == OP_LDI || opc == OP_STI)      nxt = S_RDP;
            else if (opc == OP_ST || opc == OP_STR)  nxt = S_SD;
            else                                     nxt = S_RD;
         end
         S_RDP: begin
            ctl.mem_en = 1'b1;
            if (mem_ready) begin ctl.ld_mdr = 1'b1; nxt = S_PTR; end
         end
         S_PTR: begin
            ctl.gate[GI_MDR] = 1'b1; ctl.ld_mar = 1'b1;
            nxt = (opc == OP_STI) ? S_SD : S_RD;
         end
         S_RD: begin
            ctl.mem_en = 1'b1;
            if (mem_ready) begin
               ctl.ld_mdr = 1'b1;
               nxt = (opc == OP_TRAP) ? S_TPC : S_WB;
            end
         end
         S_WB: begin
            ctl.gate[GI_MDR] = 1'b1; ctl.ld_reg = 1'b1; ctl.ld_cc = 1'b1; nxt = S_FMAR;
         end
         S_SD: begin
            ctl.sr1 = ir[11:9]; ctl.gate[GI_REG] = 1'b1; ctl.ld_mdr = 1'b1; nxt = S_WR;
         end
         S_WR: begin
            ctl.mem_en = 1'b1; ctl.mem_we = 1'b1;
            if (mem_ready) nxt = S_FMAR;
         end
         S_BR: begin
            ctl.amode = AM_PC9; ctl.pc_sel = PCS_REL; ctl.ld_pc = br_taken; nxt = S_FMAR;
         end
         S_JMP: begin
            ctl.amode = AM_BASE0; ctl.pc_sel = PCS_BASE; ctl.ld_pc = 1'b1; nxt = S_FMAR;
         end
         S_LINK: begin
            ctl.gate[GI_PC] = 1'b1; ctl.dr = LINK_IDX; ctl.ld_reg = 1'b1;
            nxt = (opc == OP_TRAP) ? S_TEA : S_JSR;
         end
         S_JSR: begin
            ctl.amode  = ir[11] ? AM_PC11 : AM_BASE0;
            ctl.pc_sel = ir[11] ? PCS_REL : PCS_BASE;
            ctl.ld_pc  = 1'b1; nxt = S_FMAR;
         end
         S_TEA: begin
            ctl.amode = AM_VEC; ctl.gate[GI_ADR] = 1'b1; ctl.ld_mar = 1'b1; nxt = S_RD;
         end
         S_TPC: begin
            ctl.gate[GI_MDR] = 1'b1; ctl.pc_sel = PCS_BUS; ctl.ld_pc = 1'b1; nxt = S_FMAR;
         end
         S_ILL:   nxt = S_ILL;
         default: nxt = S_ILL;
      endcase
   end
endmodule

// File: rtl/bus_seq_mux.sv
`timescale 1ns/1ps
module bus_seq_mux #(
   parameter int DW       = 16,
   parameter int NSRC     = 5,
   parameter bit AND_OR   = 1'b1
) (
   input  logic [NSRC-1:0] gate,
   input  logic [DW-1:0]   src [NSRC],
   output logic [DW-1:0]   bus
);
   if (AND_OR) begin : g_andor
      always_comb begin
         bus = '0;
         for (int i = 0; i < NSRC; i++) bus = bus | (src[i] & {DW{gate[i]}});
      end
   end else begin : g_prio
      always_comb begin
         bus = '0;
         for (int i = NSRC - 1; i >= 0; i--) if (gate[i]) bus = src[i];
      end
   end
endmodule

// File: rtl/bus_seq_regs.sv
`timescale 1ns/1ps
module bus_seq_regs
   import bus_seq_pkg::*;
#(
   parameter int          DW         = 16,
   parameter logic [DW-1:0] START_ADDR = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] bus,
   input  logic [DW-1:0] mem_rdata,
   input  logic [DW-1:0] addr_res,
   input  logic          ld_mar,
   input  logic          ld_mdr,
   input  logic          mem_en,
   input  logic          ld_pc,
   input  logic [1:0]    pc_sel,
   output logic [DW-1:0] mar_q,
   output logic [DW-1:0] mdr_q,
   output logic [DW-1:0] pc_q
);
   logic [DW-1:0] pc_nxt;

   always_comb begin
      unique case (pc_sel)
         PCS_INC:  pc_nxt = pc_q + DW'(1);
         PCS_REL,
         PCS_BASE: pc_nxt = addr_res;
         default:  pc_nxt = bus;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q  <= START_ADDR;
         mar_q <= '0;
         mdr_q <= '0;
      end else begin
         if (ld_pc)  pc_q  <= pc_nxt;
         if (ld_mar) mar_q <= bus;
         if (ld_mdr) mdr_q <= mem_en ? mem_rdata : bus;
      end
   end
endmodule

// File: rtl/bus_seq_ctrl.sv
`timescale 1ns/1ps
module bus_seq_ctrl
   import bus_seq_pkg::*;
#(
   parameter int            DW         = 16,
   parameter logic [DW-1:0] START_ADDR = DW'(16'h0030),
   parameter int            LINK_REG   = 7,
   parameter bit            BUS_AND_OR = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [15:0]   ir_word,
   input  logic          br_taken,
   input  logic          mem_ready,
   input  logic [DW-1:0] mem_rdata,
   input  logic [DW-1:0] alu_res,
   input  logic [DW-1:0] addr_res,
   input  logic [DW-1:0] reg_rd,
   output logic [DW-1:0] bus_q,
   output logic [4:0]    gate_oh,
   output logic          ld_mar,
   output logic          ld_mdr,
   output logic          ld_ir,
   output logic          ld_pc,
   output logic          ld_reg,
   output logic          ld_cc,
   output logic [1:0]    pc_sel,
   output logic [2:0]    addr_mode,
   output logic          op2_imm,
   output logic [1:0]    alu_fn,
   output logic [2:0]    sr1_idx,
   output logic [2:0]    sr2_idx,
   output logic [2:0]    dr_idx,
   output logic          mem_en,
   output logic          mem_we,
   output logic [DW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic [DW-1:0] pc_q,
   output logic          illegal
);
   if (DW < 16) begin : g_bad_dw
      $error("bus_seq_ctrl: DW must be at least 16");
   end
   if (LINK_REG < 0 || LINK_REG > 7) begin : g_bad_link
      $error("bus_seq_ctrl: LINK_REG must index one of eight registers");
   end

   seq_ctrl_t     ctl;
   logic [DW-1:0] mar_q, mdr_q;
   logic [DW-1:0] srcs [GN];

   bus_seq_fsm #(.LINK_REG(LINK_REG)) i_fsm (
      .clk(clk), .rst_n(rst_n), .ir(ir_word), .br_taken(br_taken),
      .mem_ready(mem_ready), .ctl(ctl), .halted(illegal)
   );

   assign srcs[GI_PC]  = pc_q;
   assign srcs[GI_MDR] = mdr_q;
   assign srcs[GI_ALU] = alu_res;
   assign srcs[GI_ADR] = addr_res;
   assign srcs[GI_REG] = reg_rd;

   bus_seq_mux #(.DW(DW), .NSRC(GN), .AND_OR(BUS_AND_OR)) i_mux (
      .gate(ctl.gate), .src(srcs), .bus(bus_q)
   );

   bus_seq_regs #(.DW(DW), .START_ADDR(START_ADDR)) i_regs (
      .clk(clk), .rst_n(rst_n), .bus(bus_q), .mem_rdata(mem_rdata),
      .addr_res(addr_res), .ld_mar(ctl.ld_mar), .ld_mdr(ctl.ld_mdr),
      .mem_en(ctl.mem_en), .ld_pc(ctl.ld_pc), .pc_sel(ctl.pc_sel),
      .mar_q(mar_q), .mdr_q(mdr_q), .pc_q(pc_q)
   );

   assign gate_oh   = ctl.gate;
   assign ld_mar    = ctl.ld_mar;
   assign ld_mdr    = ctl.ld_mdr;
   assign ld_ir     = ctl.ld_ir;
   assign ld_pc     = ctl.ld_pc;
   assign ld_reg    = ctl.ld_reg;
   assign ld_cc     = ctl.ld_cc;
   assign pc_sel    = ctl.pc_sel;
   assign addr_mode = ctl.amode;
   assign op2_imm   = ctl.op2_imm;
   assign alu_fn    = ctl.alu_fn;
   assign sr1_idx   = ctl.sr1;
   assign sr2_idx   = ir_word[2:0];
   assign dr_idx    = ctl.dr;
   assign mem_en    = ctl.mem_en;
   assign mem_we    = ctl.mem_we;
   assign mem_addr  = mar_q;
   assign mem_wdata = mdr_q;
endmodule

// File: rtl/bus_seq_chk.sv
`timescale 1ns/1ps
module bus_seq_chk #(
   parameter int DW       = 16,
   parameter int LINK_REG = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_ready,
   input logic [4:0]    gate_oh,
   input logic          ld_mar,
   input logic          ld_ir,
   input logic          ld_pc,
   input logic          ld_reg,
   input logic          ld_cc,
   input logic [1:0]    pc_sel,
   input logic [2:0]    dr_idx,
   input logic          mem_en,
   input logic          mem_we,
   input logic [DW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata,
   input logic [DW-1:0] pc_q,
   input logic          illegal
);
   localparam logic [2:0] LINK_IDX = 3'(LINK_REG);

   p_one_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gate_oh));

   p_fetch_ir_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_ir |-> (gate_oh == 5'b00010 && ld_pc && pc_sel == 2'd0));

   p_decode_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_ir |=> (gate_oh == 5'b0 && !ld_mar && !ld_pc && !ld_reg && !mem_en));

   p_pc_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_pc && pc_sel == 2'd0) |=> (pc_q == $past(pc_q) + DW'(1)));

   p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_ready) |=> (mem_en && $stable(mem_we) && $stable(mem_addr)
                                  && $stable(mem_wdata)));

   p_we_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_en);

   p_link_no_cc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_reg && gate_oh[0]) |-> (dr_idx == LINK_IDX && !ld_cc));

   p_halt_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |=> (illegal && gate_oh == 5'b0 && !mem_en && !ld_pc && !ld_reg));
endmodule

bind bus_seq_ctrl bus_seq_chk #(.DW(DW), .LINK_REG(LINK_REG)) i_chk (
   .clk(clk), .rst_n(rst_n), .mem_ready(mem_ready), .gate_oh(gate_oh),
   .ld_mar(ld_mar), .ld_ir(ld_ir), .ld_pc(ld_pc), .ld_reg(ld_reg), .ld_cc(ld_cc),
   .pc_sel(pc_sel), .dr_idx(dr_idx), .mem_en(mem_en), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pc_q(pc_q), .illegal(illegal)
);

// File: tb/test_bus_seq_ctrl.sv
`timescale 1ns/1ps
module test_bus_seq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ir_q;
   logic        br_taken, mem_ready;
   logic [15:0] mem_rdata, alu_res, addr_res, reg_rd;
   logic [15:0] bus_q, mem_addr, mem_wdata, pc_q;
   logic [4:0]  gate_oh;
   logic        ld_mar, ld_mdr, ld_ir, ld_pc, ld_reg, ld_cc, op2_imm, mem_en, mem_we, illegal;
   logic [1:0]  pc_sel, alu_fn;
   logic [2:0]  addr_mode, sr1_idx, sr2_idx, dr_idx;

   logic [15:0] mem [256];
   logic [15:0] rf [8];
   logic [2:0]  cc;
   int          wcnt, wait_n;
   int          n_chk = 0, n_bad = 0, gate_bad = 0, we_bad = 0;
   bit          done = 0;

   always #5 clk = ~clk;

   bus_seq_ctrl i_bus_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .ir_word(ir_q), .br_taken(br_taken),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata), .alu_res(alu_res),
      .addr_res(addr_res), .reg_rd(reg_rd), .bus_q(bus_q), .gate_oh(gate_oh),
      .ld_mar(ld_mar), .ld_mdr(ld_mdr), .ld_ir(ld_ir), .ld_pc(ld_pc),
      .ld_reg(ld_reg), .ld_cc(ld_cc), .pc_sel(pc_sel), .addr_mode(addr_mode),
      .op2_imm(op2_imm), .alu_fn(alu_fn), .sr1_idx(sr1_idx), .sr2_idx(sr2_idx),
      .dr_idx(dr_idx), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .pc_q(pc_q), .illegal(illegal)
   );

   // datapath environment: register file, flags, ALU, address adder, memory
   always_comb begin
      logic [15:0] op2;
      op2 = op2_imm ? {{11{ir_q[4]}}, ir_q[4:0]} : rf[sr2_idx];
      case (alu_fn)
         2'd1:    alu_res = rf[sr1_idx] & op2;
         2'd2:    alu_res = ~rf[sr1_idx];
         default: alu_res = rf[sr1_idx] + op2;
      endcase
      case (addr_mode)
         3'd0:    addr_res = pc_q + {{7{ir_q[8]}}, ir_q[8:0]};
         3'd1:    addr_res = pc_q + {{5{ir_q[10]}}, ir_q[10:0]};
         3'd2:    addr_res = rf[sr1_idx] + {{10{ir_q[5]}}, ir_q[5:0]};
         3'd3:    addr_res = rf[sr1_idx];
         default: addr_res = {8'h00, ir_q[7:0]};
      endcase
      reg_rd    = rf[sr1_idx];
      br_taken  = |(ir_q[11:9] & cc);
      mem_ready = mem_en && (wcnt == wait_n);
      mem_rdata = mem[mem_addr[7:0]];
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= 16'h8000;
         mem[8'h30] <= 16'h1642; mem[8'h31] <= 16'h187E; mem[8'h32] <= 16'h5AC1;
         mem[8'h33] <= 16'h90FF; mem[8'h34] <= 16'h3620; mem[8'h35] <= 16'h7982;
         mem[8'h36] <= 16'hB010; mem[8'h37] <= 16'h260D; mem[8'h38] <= 16'h69BF;
         mem[8'h39] <= 16'hAA0E; mem[8'h3A] <= 16'h0401; mem[8'h3B] <= 16'h1DA1;
         mem[8'h3C] <= 16'h0801; mem[8'h3D] <= 16'hE402; mem[8'h3E] <= 16'h4803;
         mem[8'h42] <= 16'hF005; mem[8'h50] <= 16'hE203; mem[8'h51] <= 16'hC040;
         mem[8'h54] <= 16'hD000;
         mem[8'h05] <= 16'h0050; mem[8'h45] <= 16'h1234; mem[8'h47] <= 16'h0090;
         mem[8'h48] <= 16'h0091; mem[8'h91] <= 16'h0000; mem[8'h7F] <= 16'hBEEF;
         for (int i = 0; i < 8; i++) rf[i] <= 16'h0000;
         rf[1] <= 16'h0005; rf[2] <= 16'h0003; rf[6] <= 16'h0080;
         ir_q <= 16'h0000; cc <= 3'b010; wcnt <= 0;
      end else begin
         if (ld_ir)  ir_q <= bus_q;
         if (ld_reg) rf[dr_idx] <= bus_q;
         if (ld_cc)  cc <= {bus_q[15], bus_q == 16'h0, !bus_q[15] && bus_q != 16'h0};
         if (mem_en && mem_we && mem_ready) mem[mem_addr[7:0]] <= mem_wdata;
         if (mem_en && !mem_ready) wcnt <= wcnt + 1; else wcnt <= 0;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if ($countones(gate_oh) > 1) gate_bad++;
         if (mem_we && !mem_en)        we_bad++;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary;
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic run(input int w);
      int cyc;
      wait_n = w;
      rst_n  = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 pc at start", 32'(pc_q), 32'h0030);
      chk("R1 first fetch step gate/mar", {27'd0, gate_oh}, 32'h1);
      chk("R1 mar load in reset", 32'(ld_mar), 32'h1);
      chk("R12 illegal low after reset", 32'(illegal), 32'h0);
      rst_n = 1'b1;
      cyc = 0;
      while (!illegal && cyc < 3000) begin
         @(posedge clk); @(negedge clk); cyc++;
      end
      // R2 R11: every path's state count plus waits per access
      chk("R11 R2 cycle count to halt", 32'(cyc), 32'(109 + 27 * w));
      chk("R4 not result R0", 32'(rf[0]), 32'hFFF7);
      chk("R9 jmp target via lea R1", 32'(rf[1]), 32'h0054);
      chk("R8 not-taken branch keeps lea R2", 32'(rf[2]), 32'h0040);
      chk("R5 ld result R3", 32'(rf[3]), 32'h1234);
      chk("R5 ldr negative offset R4", 32'(rf[4]), 32'hBEEF);
      chk("R6 ldi result R5", 32'(rf[5]), 32'h0000);
      chk("R8 taken branch skips write R6", 32'(rf[6]), 32'h0080);
      chk("R10 trap link R7", 32'(rf[7]), 32'h0043);
      chk("R7 st word", 32'(mem[8'h55]), 32'h0008);
      chk("R7 str word", 32'(mem[8'h82]), 32'h0003);
      chk("R6 sti via pointer", 32'(mem[8'h90]), 32'hFFF7);
      chk("R6 pointer untouched", 32'(mem[8'h47]), 32'h0090);
      chk("R12 pc after illegal fetch", 32'(pc_q), 32'h0055);
      repeat (8) @(negedge clk);
      chk("R12 halt sticky", 32'(illegal), 32'h1);
      chk("R12 halt quiet", {26'd0, gate_oh, mem_en}, 32'h0);
      chk("R12 pc frozen", 32'(pc_q), 32'h0055);
   endtask

   initial begin
      run(0);
      run(3);
      chk("R3 at most one gate", 32'(gate_bad), 32'h0);
      chk("R7 write only with enable", 32'(we_bad), 32'h0);
      summary();
   end

   initial begin
      #(200000 * 10);
      n_chk++; n_bad++;
      $display("FAIL watchdog R2 run did not complete actual=hung expected=done");
      summary();
   end
endmodule